// File: doc/BRIEF.md
# Flash Command Interface Controller

This block is the command front end of a parallel NOR-style flash device. The chip-enable, output-enable, write-enable, reset/power-down, write-protect and programming-supply-lockout pins, along with the address and data buses, come in asynchronously. They are brought into an internal clock domain through two-flop synchronisers. A rising write-enable edge while chip enable is low counts as a bus write. The block decodes that write as a command. A small write state machine runs the two-cycle program and erase sequences and hands the finished operation to the storage array over a request/acknowledge port.

Each read drives the data bus with one of three sources: array data, an identifier, or the 8-bit status register. The bus is released whenever the part is not selected, its outputs are disabled, or it is held in reset. Write protection covers the two lowest blocks of the address space. A low programming supply blocks all array changes. Both refusals are reported as sticky error bits in the status register.

Top module: `flash_cmd_front`

## Requirements
- R1: A bus write is accepted only on a rising edge of we_n while ce_n is low; a we_n pulse with ce_n high has no effect. The address and data in force while both were low are the values used.
- R2: dq_oe is high only while ce_n and oe_n are both low and rp_n is high; otherwise the data bus is released.
- R3: Command 0xFF selects array reads (dq_out = rd_data at rd_addr). Command 0x90 selects identifier reads (address bit 0 = 0 gives MFR_ID, 1 gives DEV_ID). Command 0x70 selects status reads (dq_out = status byte).
- R4: Program is 0x40 followed by a second write. The second write's address and data go out on arr_addr/arr_wdata with arr_erase = 0. arr_req stays high, with those values stable, until arr_ack.
- R5: Erase is 0x20 followed by 0xD0, which requests an erase (arr_erase = 1) at the second write's address. Any other second byte sets status bits 4 and 5, issues no request and returns to array reads.
- R6: While wp_n is low, addresses whose bits [AW-1:BLK_SHIFT] are below 2 are locked. A program there sets status bits 1 and 4, an erase sets bits 1 and 5, and no request is issued.
- R7: While vpp_low is high, a program sets status bits 3 and 4 and an erase sets bits 3 and 5, and no request is issued. This check takes precedence over the write-protect check.
- R8: Status bit 7 (ready) is low from the second write of an accepted operation until arr_ack; bus writes in that window are ignored.
- R9: After a program or erase sequence ends, whether it completes or is refused, reads return the status byte until a new command is written.
- R10: Error bits 1, 3, 4 and 5 stay set across later operations until command 0x50 clears them; status bits 0, 2 and 6 are always zero.
- R11: While rp_n is low the bus is released, any operation is abandoned and the error bits clear. After rp_n returns high, reads return array data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| rp_n | input | 1 | Reset/power-down, active low, asynchronous |
| wp_n | input | 1 | Write protect for the two low blocks, active low |
| vpp_low | input | 1 | High when the programming supply is below lockout |
| addr | input | AW | Address bus |
| dq_in | input | DW | Data bus, incoming side |
| dq_out | output | DW | Data bus, outgoing side |
| dq_oe | output | 1 | Data bus drive enable |
| rd_addr | output | AW | Synchronised read address to the array |
| rd_data | input | DW | Array read data for rd_addr |
| arr_req | output | 1 | Array program/erase request |
| arr_erase | output | 1 | 1 = erase, 0 = program |
| arr_addr | output | AW | Latched operation address |
| arr_wdata | output | DW | Latched program data |
| arr_ack | input | 1 | Array completion, one cycle |

## Verification
The hardest state to reach from the ports is the busy window: a read and a stray command have to land while the array has not yet acknowledged. The bench's array model therefore uses an adjustable acknowledge delay. It is stretched to forty cycles so that a status read and an ignored 0xFF write both fit inside the operation. The sticky error case needs a refused operation followed by a successful one with no clear in between, so a directed sequence toggles wp_n between the two.

// File: rtl/flash_cmd_pkg.sv
// Package: shared command codes and state types for the flash command front end.
// Assumes 8-bit command bytes carried in the low byte of the data bus.
package flash_cmd_pkg;
    localparam logic [7:0] CMD_READ_ARRAY = 8'hFF;
    localparam logic [7:0] CMD_READ_ID    = 8'h90;
    localparam logic [7:0] CMD_READ_SR    = 8'h70;
    localparam logic [7:0] CMD_CLEAR_SR   = 8'h50;
    localparam logic [7:0] CMD_PROG_SETUP = 8'h40;
    localparam logic [7:0] CMD_ERASE_SET  = 8'h20;
    localparam logic [7:0] CMD_ERASE_GO   = 8'hD0;

    typedef enum logic [1:0] {
        MODE_ARRAY  = 2'd0,
        MODE_ID     = 2'd1,
        MODE_STATUS = 2'd2
    } rd_mode_t;

    typedef enum logic [1:0] {
        WS_IDLE   = 2'd0,
        WS_PSETUP = 2'd1,
        WS_ESETUP = 2'd2,
        WS_BUSY   = 2'd3
    } wsm_state_t;
endpackage

// File: rtl/flash_in_sync.sv
// Two-flop synchroniser for a bundle of asynchronous inputs.
// Assumes multi-bit buses are stable while sampled (bus timing guarantees it).
module flash_in_sync #(
    parameter int          W         = 1,
    parameter logic [W-1:0] RST_VALUE = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    logic [W-1:0] stage1;

    // Two register stages into the clock domain, reset to the idle level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= RST_VALUE;
            d_sync <= RST_VALUE;
        end else begin
            stage1 <= d_async;
            d_sync <= stage1;
        end
    end
endmodule

// File: rtl/flash_wsm.sv
// Command decoder and write state machine. Detects bus writes on the rising
// synchronised we edge, runs program/erase two-cycle sequences, applies
// protection and lockout, and keeps the status register.
// Assumes all inputs are already synchronised to clk.
module flash_wsm
    import flash_cmd_pkg::*;
#(
    parameter int AW          = 12,
    parameter int DW          = 8,
    parameter int BLK_SHIFT   = 8,
    parameter int LOCK_BLOCKS = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rp_s,
    input  logic          ce_s,
    input  logic          we_s,
    input  logic          wp_s,
    input  logic          vpp_s,
    input  logic [AW-1:0] addr_s,
    input  logic [DW-1:0] data_s,
    input  logic          arr_ack,
    output logic          arr_req,
    output logic          arr_erase,
    output logic [AW-1:0] arr_addr,
    output logic [DW-1:0] arr_wdata,
    output rd_mode_t      mode,
    output logic [7:0]    sr
);
    localparam int BW = AW - BLK_SHIFT;
    localparam logic [BW-1:0] LOCK_LIM = BW'(LOCK_BLOCKS);

    wsm_state_t    state;
    logic          we_q;
    logic [AW-1:0] lat_a;
    logic [DW-1:0] lat_d;
    logic          e1, e3, e4, e5;
    logic          wr_stb;
    logic          locked;
    logic [7:0]    cmd;

    assign wr_stb = we_s && !we_q && !ce_s;
    assign cmd    = lat_d[7:0];
    assign locked = !wp_s && (lat_a[AW-1:BLK_SHIFT] < LOCK_LIM);

    // Sequencer, mode and error-bit update; rp low acts as a second reset.
    always_ff @(posedge clk) begin
        if (!rst_n || !rp_s) begin
            state     <= WS_IDLE;
            mode      <= MODE_ARRAY;
            we_q      <= 1'b1;
            lat_a     <= '0;
            lat_d     <= '0;
            arr_addr  <= '0;
            arr_wdata <= '0;
            arr_erase <= 1'b0;
            {e1, e3, e4, e5} <= 4'b0;
        end else begin
            we_q <= we_s;
            if (!we_s && !ce_s) begin
                lat_a <= addr_s;
                lat_d <= data_s;
            end
            case (state)
                WS_IDLE: if (wr_stb) begin
                    case (cmd)
                        CMD_READ_ARRAY: mode <= MODE_ARRAY;
                        CMD_READ_ID:    mode <= MODE_ID;
                        CMD_READ_SR:    mode <= MODE_STATUS;
                        CMD_CLEAR_SR:   {e1, e3, e4, e5} <= 4'b0;
                        CMD_PROG_SETUP: begin
                            state <= WS_PSETUP;
                            mode  <= MODE_STATUS;
                        end
                        CMD_ERASE_SET: begin
                            state <= WS_ESETUP;
                            mode  <= MODE_STATUS;
                        end
                        default: ;
                    endcase
                end
                WS_PSETUP: if (wr_stb) begin
                    arr_addr  <= lat_a;
                    arr_wdata <= lat_d;
                    arr_erase <= 1'b0;
                    if (vpp_s) begin
                        e3 <= 1'b1; e4 <= 1'b1; state <= WS_IDLE;
                    end else if (locked) begin
                        e1 <= 1'b1; e4 <= 1'b1; state <= WS_IDLE;
                    end else begin
                        state <= WS_BUSY;
                    end
                end
                WS_ESETUP: if (wr_stb) begin
                    if (cmd != CMD_ERASE_GO) begin
                        e4 <= 1'b1; e5 <= 1'b1;
                        mode  <= MODE_ARRAY;
                        state <= WS_IDLE;
                    end else begin
                        arr_addr  <= lat_a;
                        arr_erase <= 1'b1;
                        if (vpp_s) begin
                            e3 <= 1'b1; e5 <= 1'b1; state <= WS_IDLE;
                        end else if (locked) begin
                            e1 <= 1'b1; e5 <= 1'b1; state <= WS_IDLE;
                        end else begin
                            state <= WS_BUSY;
                        end
                    end
                end
                WS_BUSY: if (arr_ack) state <= WS_IDLE;
                default: state <= WS_IDLE;
            endcase
        end
    end

    assign arr_req = (state == WS_BUSY);
    assign sr      = {state != WS_BUSY, 1'b0, e5, e4, e3, 1'b0, e1, 1'b0};
endmodule

// File: rtl/flash_out_mux.sv
// Read-data source select and bus drive enable.
// Assumes identifier reads decode only address bit 0.
module flash_out_mux
    import flash_cmd_pkg::*;
#(
    parameter int          DW     = 8,
    parameter logic [DW-1:0] MFR_ID = 8'h5C,
    parameter logic [DW-1:0] DEV_ID = 8'hC3
) (
    input  rd_mode_t      mode,
    input  logic          rp_s,
    input  logic          ce_s,
    input  logic          oe_s,
    input  logic          a0_s,
    input  logic [DW-1:0] rd_data,
    input  logic [7:0]    sr,
    output logic [DW-1:0] dq_out,
    output logic          dq_oe
);
    // Pick the source for the current read mode.
    always_comb begin
        case (mode)
            MODE_ID:     dq_out = a0_s ? DEV_ID : MFR_ID;
            MODE_STATUS: dq_out = DW'(sr);
            default:     dq_out = rd_data;
        endcase
    end

    assign dq_oe = rp_s && !ce_s && !oe_s;
endmodule

// File: rtl/flash_cmd_front.sv
// Top of the flash command front end: synchronisers, write state machine
// and output select. The array sits behind rd_addr/rd_data for reads and
// arr_req/arr_ack for program and erase.
module flash_cmd_front #(
    parameter int AW          = 12,
    parameter int DW          = 8,
    parameter int BLK_SHIFT   = 8,
    parameter int LOCK_BLOCKS = 2,
    parameter logic [DW-1:0] MFR_ID = 8'h5C,
    parameter logic [DW-1:0] DEV_ID = 8'hC3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic          rp_n,
    input  logic          wp_n,
    input  logic          vpp_low,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] dq_in,
    output logic [DW-1:0] dq_out,
    output logic          dq_oe,
    output logic [AW-1:0] rd_addr,
    input  logic [DW-1:0] rd_data,
    output logic          arr_req,
    output logic          arr_erase,
    output logic [AW-1:0] arr_addr,
    output logic [DW-1:0] arr_wdata,
    input  logic          arr_ack
);
    import flash_cmd_pkg::*;

    logic          ce_s, oe_s, we_s, rp_s, wp_s, vpp_s;
    logic [AW-1:0] addr_s;
    logic [DW-1:0] data_s;
    rd_mode_t      mode;
    logic [7:0]    sr;

    flash_in_sync #(.W(6), .RST_VALUE(6'b110111)) ctl_sync_i (
        .clk(clk), .rst_n(rst_n),
        .d_async({vpp_low, wp_n, rp_n, we_n, oe_n, ce_n}),
        .d_sync ({vpp_s, wp_s, rp_s, we_s, oe_s, ce_s})
    );

    flash_in_sync #(.W(AW + DW), .RST_VALUE('0)) bus_sync_i (
        .clk(clk), .rst_n(rst_n),
        .d_async({addr, dq_in}),
        .d_sync ({addr_s, data_s})
    );

    flash_wsm #(.AW(AW), .DW(DW), .BLK_SHIFT(BLK_SHIFT), .LOCK_BLOCKS(LOCK_BLOCKS)) wsm_i (
        .clk(clk), .rst_n(rst_n), .rp_s(rp_s), .ce_s(ce_s), .we_s(we_s),
        .wp_s(wp_s), .vpp_s(vpp_s), .addr_s(addr_s), .data_s(data_s),
        .arr_ack(arr_ack), .arr_req(arr_req), .arr_erase(arr_erase),
        .arr_addr(arr_addr), .arr_wdata(arr_wdata), .mode(mode), .sr(sr)
    );

    flash_out_mux #(.DW(DW), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) out_i (
        .mode(mode), .rp_s(rp_s), .ce_s(ce_s), .oe_s(oe_s), .a0_s(addr_s[0]),
        .rd_data(rd_data), .sr(sr), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    assign rd_addr = addr_s;
endmodule

// File: rtl/flash_cmd_front_chk.sv
// Protocol checker for flash_cmd_front, attached by bind below.
// Observes synchronised pins, the array port and the status byte.
module flash_cmd_front_chk #(
    parameter int AW          = 12,
    parameter int DW          = 8,
    parameter int BLK_SHIFT   = 8,
    parameter int LOCK_BLOCKS = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rp_s,
    input logic          ce_s,
    input logic          oe_s,
    input logic          wp_s,
    input logic          vpp_s,
    input logic          dq_oe,
    input logic          arr_req,
    input logic          arr_ack,
    input logic          arr_erase,
    input logic [AW-1:0] arr_addr,
    input logic [DW-1:0] arr_wdata,
    input logic [7:0]    sr
);
    localparam int BW = AW - BLK_SHIFT;
    localparam logic [BW-1:0] LOCK_LIM = BW'(LOCK_BLOCKS);

    assert_bus_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_s || oe_s || !rp_s) |-> !dq_oe);

    assert_req_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_req && !arr_ack) |=> (arr_req && $stable(arr_addr) &&
                                   $stable(arr_wdata) && $stable(arr_erase)));

    assert_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(arr_req) && !$past(wp_s)) |-> (arr_addr[AW-1:BLK_SHIFT] >= LOCK_LIM));

    assert_vpp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arr_req) |-> !$past(vpp_s));

    assert_busy_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        arr_req |-> !sr[7]);

    assert_pwrdn_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rp_s |=> (!arr_req && sr == 8'h80));
endmodule

bind flash_cmd_front flash_cmd_front_chk #(
    .AW(AW), .DW(DW), .BLK_SHIFT(BLK_SHIFT), .LOCK_BLOCKS(LOCK_BLOCKS)
) chk_i (
    .clk(clk), .rst_n(rst_n), .rp_s(rp_s), .ce_s(ce_s), .oe_s(oe_s),
    .wp_s(wp_s), .vpp_s(vpp_s), .dq_oe(dq_oe), .arr_req(arr_req),
    .arr_ack(arr_ack), .arr_erase(arr_erase), .arr_addr(arr_addr),
    .arr_wdata(arr_wdata), .sr(sr)
);

// File: tb/flash_cmd_front_tb_top.sv
module flash_cmd_front_tb_top;
    localparam int AW = 12;
    localparam int DW = 8;
    localparam logic [7:0] MFR = 8'h5C;
    localparam logic [7:0] DEV = 8'hC3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, rp_n = 1'b1, wp_n = 1'b1, vpp_low = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] dq_in = '0;
    logic [DW-1:0] dq_out, rd_data, arr_wdata;
    logic [AW-1:0] rd_addr, arr_addr;
    logic dq_oe, arr_req, arr_erase;
    logic arr_ack = 1'b0;

    int checks = 0, failures = 0;
    int req_count = 0, ack_delay = 3, ack_cnt = 0;
    logic [AW-1:0] last_addr = '0;
    logic [DW-1:0] last_data = '0;
    logic last_erase = 1'b0;
    logic done = 1'b0;

    always #10 clk = ~clk;

    assign rd_data = rd_addr[7:0] ^ 8'h5A;

    flash_cmd_front dut_i (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .rp_n(rp_n), .wp_n(wp_n), .vpp_low(vpp_low), .addr(addr), .dq_in(dq_in),
        .dq_out(dq_out), .dq_oe(dq_oe), .rd_addr(rd_addr), .rd_data(rd_data),
        .arr_req(arr_req), .arr_erase(arr_erase), .arr_addr(arr_addr),
        .arr_wdata(arr_wdata), .arr_ack(arr_ack)
    );

    // Array model: acknowledge after ack_delay cycles and record the operation.
    always @(posedge clk) begin
        if (arr_ack) begin
            arr_ack <= 1'b0;
            ack_cnt <= 0;
        end else if (arr_req) begin
            if (ack_cnt >= ack_delay) begin
                arr_ack    <= 1'b1;
                req_count  <= req_count + 1;
                last_addr  <= arr_addr;
                last_data  <= arr_wdata;
                last_erase <= arr_erase;
                ack_cnt    <= 0;
            end else begin
                ack_cnt <= ack_cnt + 1;
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [7:0] d, input logic sel = 1'b1);
        @(negedge clk);
        addr = a; dq_in = d; ce_n = !sel;
        repeat (2) @(negedge clk);
        we_n = 1'b0;
        repeat (4) @(negedge clk);
        we_n = 1'b1;
        repeat (4) @(negedge clk);
        ce_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [7:0] d, output logic oe);
        @(negedge clk);
        addr = a; ce_n = 1'b0; oe_n = 1'b0;
        repeat (5) @(negedge clk);
        d = dq_out; oe = dq_oe;
        oe_n = 1'b1; ce_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    typedef struct packed {
        logic          wp;
        logic          vpp;
        logic [7:0]    cmd;
        logic [AW-1:0] a;
        logic [7:0]    d;
        logic [7:0]    exp_sr;
        logic          exp_req;
    } vec_t;

    // Two-cycle sequences with the status byte and request count expected after each.
    localparam vec_t VEC [8] = '{
        '{1'b1, 1'b0, 8'h40, 12'h050, 8'hA5, 8'h80, 1'b1},  // R4 program
        '{1'b0, 1'b0, 8'h40, 12'h050, 8'h11, 8'h92, 1'b0},  // R6 locked program
        '{1'b0, 1'b0, 8'h40, 12'h350, 8'h22, 8'h80, 1'b1},  // R6 unlocked block
        '{1'b0, 1'b0, 8'h20, 12'h150, 8'hD0, 8'hA2, 1'b0},  // R6 locked erase
        '{1'b1, 1'b0, 8'h20, 12'h150, 8'hD0, 8'h80, 1'b1},  // R5 erase
        '{1'b1, 1'b1, 8'h40, 12'h350, 8'h33, 8'h98, 1'b0},  // R7 program lockout
        '{1'b1, 1'b1, 8'h20, 12'h350, 8'hD0, 8'hA8, 1'b0},  // R7 erase lockout
        '{1'b1, 1'b0, 8'h20, 12'h350, 8'hFF, 8'hB0, 1'b0}   // R5 bad confirm
    };

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic oe;
        int r0;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // Reset state: array reads, ready status (R3, R11).
        bus_read(12'h123, d, oe);
        check("R11 reset array read", d, 8'h23 ^ 8'h5A);
        check("R2 drive on read", oe, 1);
        bus_write(0, 8'h70);
        bus_read(0, d, oe);
        check("R10 reset status", d, 8'h80);

        // Table of two-cycle sequences.
        foreach (VEC[i]) begin
            @(negedge clk);
            wp_n = VEC[i].wp; vpp_low = VEC[i].vpp;
            repeat (6) @(negedge clk);
            r0 = req_count;
            bus_write(0, VEC[i].cmd);
            bus_write(VEC[i].a, VEC[i].d);
            repeat (30) @(negedge clk);
            check("R4/R5/R6/R7 request count", req_count - r0, int'(VEC[i].exp_req));
            if (VEC[i].exp_req) begin
                check("R4 array address", last_addr, VEC[i].a);
                check("R5 operation kind", last_erase, VEC[i].cmd == 8'h20);
                if (VEC[i].cmd == 8'h40) check("R4 array data", last_data, VEC[i].d);
            end
            if (VEC[i].cmd != 8'h20 || VEC[i].d == 8'hD0) begin
                bus_read(0, d, oe);
                check("R9 status without command", d, VEC[i].exp_sr);
            end else begin
                bus_read(12'h044, d, oe);
                check("R5 back to array reads", d, 8'h44 ^ 8'h5A);
            end
            bus_write(0, 8'h70);
            bus_read(0, d, oe);
            check("R6/R7 status byte", d, VEC[i].exp_sr);
            bus_write(0, 8'h50);
            @(negedge clk);
            wp_n = 1'b1; vpp_low = 1'b0;
        end

        // R10: cleared status after 0x50.
        bus_read(0, d, oe);
        check("R10 cleared status", d, 8'h80);

        // R3: identifier reads.
        bus_write(0, 8'h90);
        bus_read(12'h000, d, oe);
        check("R3 manufacturer id", d, MFR);
        bus_read(12'h001, d, oe);
        check("R3 device id", d, DEV);

        // R1: write with ce_n high is ignored; still identifier mode.
        bus_write(0, 8'hFF, 1'b0);
        bus_read(12'h000, d, oe);
        check("R1 deselected write ignored", d, MFR);
        bus_write(0, 8'hFF);
        bus_read(12'h0A0, d, oe);
        check("R3 read array command", d, 8'hA0 ^ 8'h5A);

        // R2: bus released when either enable is high.
        @(negedge clk); ce_n = 1'b0; oe_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R2 oe high releases bus", dq_oe, 0);
        ce_n = 1'b1; oe_n = 1'b0;
        repeat (5) @(negedge clk);
        check("R2 ce high releases bus", dq_oe, 0);
        oe_n = 1'b1;

        // R10: error survives a later successful program.
        @(negedge clk); wp_n = 1'b0;
        repeat (6) @(negedge clk);
        bus_write(0, 8'h40);
        bus_write(12'h010, 8'h01);
        @(negedge clk); wp_n = 1'b1;
        repeat (6) @(negedge clk);
        bus_write(0, 8'h40);
        bus_write(12'h310, 8'h02);
        repeat (30) @(negedge clk);
        bus_read(0, d, oe);
        check("R10 sticky error bits", d, 8'h92);
        bus_write(0, 8'h50);
        bus_read(0, d, oe);
        check("R10 clear status", d, 8'h80);

        // R8: long operation, status read and stray command while busy.
        ack_delay = 40;
        r0 = req_count;
        bus_write(0, 8'h40);
        bus_write(12'h320, 8'h77);
        bus_read(0, d, oe);
        check("R8 ready low while busy", d, 8'h00);
        bus_write(0, 8'hFF);
        repeat (60) @(negedge clk);
        check("R8 one request", req_count - r0, 1);
        bus_read(0, d, oe);
        check("R8/R9 ignored write, status mode", d, 8'h80);
        ack_delay = 3;

        // R11: power-down releases bus, clears errors, returns to array reads.
        @(negedge clk); vpp_low = 1'b1;
        repeat (6) @(negedge clk);
        bus_write(0, 8'h40);
        bus_write(12'h300, 8'h01);
        @(negedge clk); vpp_low = 1'b0;
        bus_write(0, 8'h90);
        @(negedge clk); rp_n = 1'b0;
        repeat (6) @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0;
        repeat (5) @(negedge clk);
        check("R11 bus released in power-down", dq_oe, 0);
        ce_n = 1'b1; oe_n = 1'b1; rp_n = 1'b1;
        repeat (6) @(negedge clk);
        bus_read(12'h0C3, d, oe);
        check("R11 array mode after wake", d, 8'hC3 ^ 8'h5A);
        bus_write(0, 8'h70);
        bus_read(0, d, oe);
        check("R11 errors cleared", d, 8'h80);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule